// File: doc/BRIEF.md
# Processor System-Control Exception Unit

This unit is the system-control coprocessor beside a 32-bit microcontroller core. Software reaches its registers with move-to and move-from operations that name a register by a 5-bit number and a 3-bit select. The unit holds the processor state word, an interrupt-control word, the exception cause, the saved restart address, and a free-running core timer with its compare value.

The pipeline offers synchronous exceptions through a valid/ready request channel. It presents the priority of the highest pending external interrupt and the restart address of the instruction in flight, and it signals a return-from-exception. The unit accepts at most one event per cycle, and in that same cycle it drives a redirect pulse with the next fetch address.

On the exception channel the source raises `exc_valid` with code and restart address and holds all three stable until `exc_ready` is high at a clock edge, which completes the transfer. The unit lowers `exc_ready` only in a cycle where `ret_cmd` is high, so a return always goes ahead of an exception offered in the same cycle.

Top module: `syscop_unit`

## Requirements
- R1: Registers are selected by (number, select): state word 12/0, interrupt control 12/1, timer count 9/0, timer compare 11/0, cause 13/0, restart address 14/0. Reading any other pair returns zero, and writing one changes no register.
- R2: The state word has the interrupt enable at bit 0, the exception-level flag at bit 1 and the priority level at bits 12:10. All other bits read as zero. Interrupt control keeps only bits 9:5. After reset every register reads zero except compare, which reads all ones.
- R3: `exc_ready` is low exactly in cycles with `ret_cmd` high. In a cycle where an exception is accepted, `redir_valid` is high and `redir_pc` equals `EXC_VEC`. After that cycle the exception-level flag is 1 and cause bits 6:2 hold `exc_code`.
- R4: An accepted exception loads the restart address register with `exc_pc` only if the exception-level flag was 0. Otherwise the restart address register is kept, while cause is still updated.
- R5: An interrupt is taken when enable is 1, exception level is 0, the request priority is strictly above the priority level, and no exception or return occupies the cycle. Taking it redirects to `IRQ_VEC`, saves `cur_pc` as the restart address, sets the exception-level flag, writes code 0 and writes the request priority into cause bits 12:10.
- R6: A return redirects in the same cycle to the saved restart address, and the exception-level flag reads 0 afterwards.
- R7: A new priority level written by software governs interrupt gating from the very next cycle.
- R8: A write to count reloads it. From then on, count advances by one on every second clock edge.
- R9: Cause bit 30 is set on the edge where count advances to the compare value. Any write to compare clears it.
- R10: While cause bit 30 is set, the timer raises an interrupt request at priority `TMR_PRIO`. It competes with the external priority, and the higher of the two is the request priority.
- R11: Cause is read-only to software. A write to it is ignored.
- R12: When a hardware event (exception, interrupt or return) occurs in a cycle, a software write to the state word or to the restart address in that same cycle is dropped.
- R13: When an exception and an interrupt arrive in the same cycle, the exception is taken. The interrupt is not taken in the next cycle either, because the exception-level flag is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Software register access in this cycle |
| acc_wr | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_num | input | 5 | Register number |
| acc_sel | input | 3 | Register select |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data of the addressed register (combinational) |
| exc_valid | input | 1 | Synchronous exception offered |
| exc_ready | output | 1 | Exception can be accepted this cycle |
| exc_code | input | 5 | Exception code of the offered exception |
| exc_pc | input | 32 | Restart address of the faulting instruction |
| irq_prio | input | 3 | Highest pending external interrupt priority, 0 = none |
| cur_pc | input | 32 | Restart address used when an interrupt is taken |
| ret_cmd | input | 1 | Return-from-exception command |
| redir_valid | output | 1 | Fetch redirect in this cycle |
| redir_pc | output | 32 | Redirect target address |

## Verification
The bench offers a synchronous exception and an external interrupt in the same cycle. In that cycle it also writes the state word, which would clear the enable. It judges the result by the redirect target in that cycle, by the absence of a redirect in the next cycle while the interrupt is still pending, and by reading back cause, the restart address and the state word. Those reads must show the exception's code and address and an unchanged enable. A second collision offers a return together with an exception and checks that the exception is held off by `exc_ready` while fetch goes to the saved address.

// File: rtl/syscop_pkg.sv
package syscop_pkg;

  localparam int unsigned CODE_W   = 5;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned IE_BIT   = 0;
  localparam int unsigned EXL_BIT  = 1;
  localparam int unsigned LVL_LSB  = 10;
  localparam int unsigned TI_BIT   = 30;
  localparam int unsigned VS_LSB   = 5;
  localparam int unsigned VS_W     = 5;

  localparam logic [4:0] NUM_COUNT   = 5'd9;
  localparam logic [4:0] NUM_COMPARE = 5'd11;
  localparam logic [4:0] NUM_STATE   = 5'd12;
  localparam logic [4:0] NUM_CAUSE   = 5'd13;
  localparam logic [4:0] NUM_EPC     = 5'd14;

  typedef enum logic [2:0] {
    ID_NONE,
    ID_STATE,
    ID_INTCTL,
    ID_CAUSE,
    ID_EPC,
    ID_COUNT,
    ID_COMPARE
  } reg_id_e;

endpackage

// File: rtl/syscop_decode.sv
module syscop_decode
  import syscop_pkg::*;
(
  input  logic [4:0] num,
  input  logic [2:0] sel,
  output reg_id_e    id
);

  always_comb begin
    id = ID_NONE;
    case ({num, sel})
      {NUM_STATE,   3'd0}: id = ID_STATE;
      {NUM_STATE,   3'd1}: id = ID_INTCTL;
      {NUM_CAUSE,   3'd0}: id = ID_CAUSE;
      {NUM_EPC,     3'd0}: id = ID_EPC;
      {NUM_COUNT,   3'd0}: id = ID_COUNT;
      {NUM_COMPARE, 3'd0}: id = ID_COMPARE;
      default:             id = ID_NONE;
    endcase
  end

endmodule

// File: rtl/syscop_timer.sv
module syscop_timer #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cnt_wr,
  input  logic            cmp_wr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] count,
  output logic [XLEN-1:0] compare,
  output logic            ti
);

  logic            phase_q;
  logic [XLEN-1:0] cnt_inc;

  assign cnt_inc = count + XLEN'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      count   <= '0;
      compare <= '1;
      ti      <= 1'b0;
    end else begin
      if (cnt_wr) begin
        count   <= wdata;
        phase_q <= 1'b0;
      end else begin
        phase_q <= ~phase_q;
        if (phase_q) count <= cnt_inc;
      end
      if (cmp_wr) compare <= wdata;
      if (cmp_wr) ti <= 1'b0;
      else if (!cnt_wr && phase_q && (cnt_inc == compare)) ti <= 1'b1;
    end
  end

  AST_CMP_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) cmp_wr |=> !ti); // R9
  AST_COUNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) cnt_wr |=> count == $past(wdata)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) !cnt_wr |=> (count == $past(count) || count == $past(count) + XLEN'(1))); // R8

endmodule

// File: rtl/syscop_arbiter.sv
module syscop_arbiter #(
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned TMR_PRIO = 5
) (
  input  logic              ie,
  input  logic              exl,
  input  logic [PRIO_W-1:0] level,
  input  logic [PRIO_W-1:0] ext_prio,
  input  logic              ti,
  input  logic              exc_valid,
  input  logic              ret_cmd,
  output logic              exc_ready,
  output logic              take_exc,
  output logic              take_irq,
  output logic [PRIO_W-1:0] req_prio
);

  logic [PRIO_W-1:0] tmr_prio;

  assign tmr_prio  = ti ? PRIO_W'(TMR_PRIO) : '0;
  assign req_prio  = (ext_prio > tmr_prio) ? ext_prio : tmr_prio;
  assign exc_ready = !ret_cmd;
  assign take_exc  = exc_valid && exc_ready;
  assign take_irq  = !take_exc && !ret_cmd && ie && !exl && (req_prio > level);

endmodule

// File: rtl/syscop_unit.sv
module syscop_unit
  import syscop_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned PRIO_W   = 3,
  parameter int unsigned TMR_PRIO = 5,
  parameter logic [31:0] EXC_VEC  = 32'h8000_0180,
  parameter logic [31:0] IRQ_VEC  = 32'h8000_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [4:0]        acc_num,
  input  logic [2:0]        acc_sel,
  input  logic [XLEN-1:0]   acc_wdata,
  output logic [XLEN-1:0]   acc_rdata,
  input  logic              exc_valid,
  output logic              exc_ready,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [PRIO_W-1:0] irq_prio,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              ret_cmd,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);

  reg_id_e           id;
  logic              ie_q, exl_q;
  logic [PRIO_W-1:0] lvl_q, ripl_q;
  logic [VS_W-1:0]   vs_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q, count, compare;
  logic              ti;
  logic              take_exc, take_irq, hw_evt, sw_wr;
  logic              wr_state, wr_intctl, wr_epc, wr_count, wr_compare;
  logic [PRIO_W-1:0] req_prio;

  syscop_decode u_decode (
    .num (acc_num),
    .sel (acc_sel),
    .id  (id)
  );

  syscop_arbiter #(.PRIO_W(PRIO_W), .TMR_PRIO(TMR_PRIO)) u_arb (
    .ie        (ie_q),
    .exl       (exl_q),
    .level     (lvl_q),
    .ext_prio  (irq_prio),
    .ti        (ti),
    .exc_valid (exc_valid),
    .ret_cmd   (ret_cmd),
    .exc_ready (exc_ready),
    .take_exc  (take_exc),
    .take_irq  (take_irq),
    .req_prio  (req_prio)
  );

  assign hw_evt     = take_exc || take_irq || ret_cmd;
  assign sw_wr      = acc_en && acc_wr;
  assign wr_state   = sw_wr && (id == ID_STATE) && !hw_evt;
  assign wr_epc     = sw_wr && (id == ID_EPC) && !hw_evt;
  assign wr_intctl  = sw_wr && (id == ID_INTCTL);
  assign wr_count   = sw_wr && (id == ID_COUNT);
  assign wr_compare = sw_wr && (id == ID_COMPARE);

  syscop_timer #(.XLEN(XLEN)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_wr  (wr_count),
    .cmp_wr  (wr_compare),
    .wdata   (acc_wdata),
    .count   (count),
    .compare (compare),
    .ti      (ti)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      exl_q  <= 1'b0;
      lvl_q  <= '0;
      vs_q   <= '0;
      code_q <= '0;
      ripl_q <= '0;
      epc_q  <= '0;
    end else begin
      if (wr_state) begin
        ie_q  <= acc_wdata[IE_BIT];
        exl_q <= acc_wdata[EXL_BIT];
        lvl_q <= acc_wdata[LVL_LSB +: PRIO_W];
      end
      if (wr_intctl) vs_q <= acc_wdata[VS_LSB +: VS_W];
      if (wr_epc) epc_q <= acc_wdata;
      if (take_exc) begin
        exl_q  <= 1'b1;
        code_q <= exc_code;
        if (!exl_q) epc_q <= exc_pc;
      end else if (take_irq) begin
        exl_q  <= 1'b1;
        code_q <= '0;
        ripl_q <= req_prio;
        epc_q  <= cur_pc;
      end else if (ret_cmd) begin
        exl_q <= 1'b0;
      end
    end
  end

  always_comb begin
    acc_rdata = '0;
    case (id)
      ID_STATE: begin
        acc_rdata[IE_BIT]               = ie_q;
        acc_rdata[EXL_BIT]              = exl_q;
        acc_rdata[LVL_LSB +: PRIO_W]    = lvl_q;
      end
      ID_INTCTL:  acc_rdata[VS_LSB +: VS_W] = vs_q;
      ID_CAUSE: begin
        acc_rdata[CODE_LSB +: CODE_W]   = code_q;
        acc_rdata[LVL_LSB +: PRIO_W]    = ripl_q;
        acc_rdata[TI_BIT]               = ti;
      end
      ID_EPC:     acc_rdata = epc_q;
      ID_COUNT:   acc_rdata = count;
      ID_COMPARE: acc_rdata = compare;
      default:    acc_rdata = '0;
    endcase
  end

  assign redir_valid = hw_evt;
  assign redir_pc    = take_exc ? EXC_VEC : (take_irq ? IRQ_VEC : epc_q);

  AST_EXC_RECORDS_CODE: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_ready) |=> (exl_q && code_q == $past(exc_code))); // R3
  AST_EPC_KEPT_NESTED: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_ready && exl_q) |=> $stable(epc_q)); // R4
  AST_IRQ_ENTRY_STATE: assert property (@(posedge clk) disable iff (!rst_n) take_irq |=> (exl_q && code_q == '0 && ripl_q == $past(req_prio) && epc_q == $past(cur_pc))); // R5
  AST_RET_CLEARS_EXL: assert property (@(posedge clk) disable iff (!rst_n) ret_cmd |=> !exl_q); // R6
  AST_NO_IRQ_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n) (exc_valid && exc_ready) |=> !take_irq); // R13

endmodule

// File: tb/syscop_unit_test.sv
module syscop_unit_test;

  localparam logic [31:0] EXC_VEC = 32'h8000_0180;
  localparam logic [31:0] IRQ_VEC = 32'h8000_0200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_wr = 1'b0;
  logic [4:0]  acc_num = '0;
  logic [2:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0, acc_rdata;
  logic        exc_valid = 1'b0, exc_ready;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0, cur_pc = '0;
  logic [2:0]  irq_prio = '0;
  logic        ret_cmd = 1'b0;
  logic        redir_valid;
  logic [31:0] redir_pc;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  syscop_unit uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr), .acc_num(acc_num),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_code(exc_code), .exc_pc(exc_pc),
    .irq_prio(irq_prio), .cur_pc(cur_pc), .ret_cmd(ret_cmd),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_num = n; acc_sel = s; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] n, input logic [2:0] s, output logic [31:0] d);
    acc_en = 1'b1; acc_wr = 1'b0; acc_num = n; acc_sel = s;
    #1 d = acc_rdata;
    acc_en = 1'b0;
  endtask

  task automatic do_return(input logic [31:0] exp_pc);
    @(negedge clk);
    ret_cmd = 1'b1;
    #1 check("R6 return redirect valid", {31'd0, redir_valid}, 32'd1);
    check("R6 return target", redir_pc, exp_pc);
    @(negedge clk);
    ret_cmd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd_reg(5'd12, 3'd0, v); check("R2 reset state word", v, 32'h0);
    rd_reg(5'd12, 3'd1, v); check("R2 reset intctl", v, 32'h0);
    rd_reg(5'd13, 3'd0, v); check("R2 reset cause", v, 32'h0);
    rd_reg(5'd14, 3'd0, v); check("R2 reset epc", v, 32'h0);
    rd_reg(5'd11, 3'd0, v); check("R2 reset compare", v, 32'hFFFF_FFFF);
    check("R3 ready after reset", {31'd0, exc_ready}, 32'd1);
    check("R2 no redirect after reset", {31'd0, redir_valid}, 32'd0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr_reg(5'd12, 3'd0, 32'hFFFF_FFFF);
    rd_reg(5'd12, 3'd0, v); check("R2 state word field mask", v, 32'h0000_1C03);
    wr_reg(5'd12, 3'd0, 32'h0000_0801);
    rd_reg(5'd12, 3'd0, v); check("R1 state word 12/0", v, 32'h0000_0801);
    wr_reg(5'd12, 3'd1, 32'hFFFF_FFFF);
    rd_reg(5'd12, 3'd1, v); check("R2 intctl 12/1 mask", v, 32'h0000_03E0);
    wr_reg(5'd14, 3'd0, 32'h0000_1234);
    rd_reg(5'd14, 3'd0, v); check("R1 epc 14/0", v, 32'h0000_1234);
    wr_reg(5'd14, 3'd1, 32'hDEAD_BEEF);
    rd_reg(5'd14, 3'd1, v); check("R1 unimplemented reads zero", v, 32'h0);
    rd_reg(5'd14, 3'd0, v); check("R1 unimplemented write ignored", v, 32'h0000_1234);
    wr_reg(5'd12, 3'd2, 32'hFFFF_FFFF);
    rd_reg(5'd12, 3'd0, v); check("R1 12/2 write leaves state word", v, 32'h0000_0801);
    wr_reg(5'd12, 3'd0, 32'h0);
  endtask

  task automatic t_cause_ro;
    logic [31:0] v;
    wr_reg(5'd13, 3'd0, 32'hFFFF_FFFF);
    rd_reg(5'd13, 3'd0, v); check("R11 cause write ignored", v, 32'h0);
  endtask

  task automatic t_exception;
    logic [31:0] v;
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd4; exc_pc = 32'h0000_0100;
    #1 check("R3 ready when no return", {31'd0, exc_ready}, 32'd1);
    check("R3 redirect valid", {31'd0, redir_valid}, 32'd1);
    check("R3 redirect to exception vector", redir_pc, EXC_VEC);
    @(negedge clk);
    exc_valid = 1'b0;
    rd_reg(5'd13, 3'd0, v); check("R3 cause code", v, 32'h0000_0010);
    rd_reg(5'd12, 3'd0, v); check("R3 exception level set", v, 32'h0000_0002);
    rd_reg(5'd14, 3'd0, v); check("R4 epc saved", v, 32'h0000_0100);
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd12; exc_pc = 32'h0000_0200;
    @(negedge clk);
    exc_valid = 1'b0;
    rd_reg(5'd14, 3'd0, v); check("R4 epc kept when nested", v, 32'h0000_0100);
    rd_reg(5'd13, 3'd0, v); check("R4 cause updated when nested", v, 32'h0000_0030);
  endtask

  task automatic t_return;
    logic [31:0] v;
    @(negedge clk);
    ret_cmd = 1'b1; exc_valid = 1'b1; exc_code = 5'd9; exc_pc = 32'h0000_0300;
    #1 check("R3 ready low during return", {31'd0, exc_ready}, 32'd0);
    check("R6 return redirect", redir_pc, 32'h0000_0100);
    @(negedge clk);
    ret_cmd = 1'b0; exc_valid = 1'b0;
    rd_reg(5'd12, 3'd0, v); check("R6 exception level cleared", v, 32'h0);
    rd_reg(5'd13, 3'd0, v); check("R3 held exception not taken", v, 32'h0000_0030);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    cur_pc = 32'h0000_0400;
    wr_reg(5'd12, 3'd0, 32'h0000_0C01);
    irq_prio = 3'd3;
    #1 check("R5 equal priority not taken", {31'd0, redir_valid}, 32'd0);
    irq_prio = 3'd4;
    #1 check("R5 higher priority redirect", {31'd0, redir_valid}, 32'd1);
    check("R5 interrupt vector", redir_pc, IRQ_VEC);
    @(negedge clk);
    irq_prio = 3'd7;
    #1 check("R5 blocked by exception level", {31'd0, redir_valid}, 32'd0);
    irq_prio = 3'd0;
    rd_reg(5'd13, 3'd0, v); check("R5 cause priority and code", v, 32'h0000_1000);
    rd_reg(5'd14, 3'd0, v); check("R5 epc from cur_pc", v, 32'h0000_0400);
    rd_reg(5'd12, 3'd0, v); check("R5 exception level set", v, 32'h0000_0C03);
    do_return(32'h0000_0400);
    wr_reg(5'd12, 3'd0, 32'h0000_1401);
    irq_prio = 3'd5;
    #1 check("R7 new level blocks next cycle", {31'd0, redir_valid}, 32'd0);
    irq_prio = 3'd6;
    #1 check("R7 above new level taken", {31'd0, redir_valid}, 32'd1);
    @(negedge clk);
    irq_prio = 3'd0;
    do_return(32'h0000_0400);
    wr_reg(5'd12, 3'd0, 32'h0);
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr_reg(5'd11, 3'd0, 32'd3);
    wr_reg(5'd9, 3'd0, 32'd0);
    rd_reg(5'd9, 3'd0, v); check("R8 count reloaded", v, 32'd0);
    step(1);
    rd_reg(5'd9, 3'd0, v); check("R8 count holds one edge", v, 32'd0);
    step(1);
    rd_reg(5'd9, 3'd0, v); check("R8 count after two edges", v, 32'd1);
    step(3);
    rd_reg(5'd9, 3'd0, v); check("R8 count after five edges", v, 32'd2);
    rd_reg(5'd13, 3'd0, v); check("R9 pending clear before match", v & 32'h4000_0000, 32'h0);
    step(1);
    rd_reg(5'd9, 3'd0, v); check("R8 count reaches compare", v, 32'd3);
    rd_reg(5'd13, 3'd0, v); check("R9 pending set on match", v & 32'h4000_0000, 32'h4000_0000);
    wr_reg(5'd11, 3'd0, 32'h0000_0100);
    rd_reg(5'd13, 3'd0, v); check("R9 compare write clears", v & 32'h4000_0000, 32'h0);
  endtask

  task automatic t_timer_irq;
    logic [31:0] v;
    cur_pc = 32'h0000_0600;
    wr_reg(5'd12, 3'd0, 32'h0000_1001);
    wr_reg(5'd11, 3'd0, 32'd2);
    wr_reg(5'd9, 3'd0, 32'd0);
    step(3);
    #1 check("R10 no request before match", {31'd0, redir_valid}, 32'd0);
    step(1);
    #1 check("R10 timer request redirect", {31'd0, redir_valid}, 32'd1);
    check("R10 timer to interrupt vector", redir_pc, IRQ_VEC);
    step(1);
    rd_reg(5'd13, 3'd0, v); check("R10 timer priority in cause", v & 32'h0000_1C7C, 32'h0000_1400);
    rd_reg(5'd14, 3'd0, v); check("R10 epc saved", v, 32'h0000_0600);
    wr_reg(5'd11, 3'd0, 32'hFFFF_FFFF);
    do_return(32'h0000_0600);
    wr_reg(5'd12, 3'd0, 32'h0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    wr_reg(5'd12, 3'd0, 32'h0000_0001);
    acc_en = 1'b1; acc_wr = 1'b1; acc_num = 5'd12; acc_sel = 3'd0; acc_wdata = 32'h0;
    exc_valid = 1'b1; exc_code = 5'd8; exc_pc = 32'h0000_0700; irq_prio = 3'd2;
    #1 check("R13 exception wins redirect", redir_pc, EXC_VEC);
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; exc_valid = 1'b0;
    #1 check("R13 interrupt not taken next", {31'd0, redir_valid}, 32'd0);
    irq_prio = 3'd0;
    rd_reg(5'd13, 3'd0, v); check("R13 cause from exception", v & 32'h0000_007C, 32'h0000_0020);
    rd_reg(5'd14, 3'd0, v); check("R13 epc from exception", v, 32'h0000_0700);
    rd_reg(5'd12, 3'd0, v); check("R12 software write dropped", v, 32'h0000_0003);
    do_return(32'h0000_0700);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_cause_ro();
    t_exception();
    t_return();
    t_irq();
    t_timer();
    t_timer_irq();
    t_collision();
    step(2);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule